// File: doc/BRIEF.md
# Eight-Bit ALU with Status Flags

This block is the arithmetic and logic core of a small accumulator processor. Each operation takes a 4-bit operation code, a register value, a memory operand and the current status byte. The register value is the accumulator or an index register. The block returns an 8-bit result and a new status byte holding Negative, Overflow, Zero and Carry. The enclosing datapath does operand fetch and addressing. Decimal-mode arithmetic is not part of this block.

The result and status are computed combinationally from the inputs. An output register captures them on any cycle where the valid strobe is high. The registered values, and a one-cycle delayed valid, are what the processor sees. Flags that an operation does not define keep the value they had on `status_i`.

Each status byte places N at bit 7, V at bit 6, D at bit 3, I at bit 2, Z at bit 1 and C at bit 0. Bits 5 and 4 always read as 1. Operation codes:

| Code | Operation |
|------|-----------|
| 0 | add with carry |
| 1 | subtract with borrow |
| 2 | compare |
| 3 | AND |
| 4 | OR |
| 5 | exclusive-OR |
| 6 | bit test |
| 7 | shift left |
| 8 | logical shift right |
| 9 | rotate left |
| 10 | rotate right |
| 11 | load/transfer of the operand |
| 12–15 | unassigned |

Top module: `alu8_core`

## Requirements
- R1: While rst_ni is low, result_o reads 0x00, status_o reads 0x30 and valid_o reads 0.
- R2: A rising clock edge with valid_i high loads result_o and status_o from the current inputs and sets valid_o for the next cycle. With valid_i low, valid_o falls and result_o and status_o hold their values whatever the other inputs do.
- R3: Add (code 0) forms reg_i + opnd_i + C in nine bits. The result is the low eight bits and C is the ninth bit. V is set when both inputs share a sign that the result lacks. N is bit 7 of the result and Z is set when the result is zero.
- R4: Subtract (code 1) forms reg_i - opnd_i - (1 - C). The result is the low eight bits. C is set when no borrow occurred. V is bit 7 of ((~opnd_i) ^ R) & (reg_i ^ R). N and Z follow the result.
- R5: Compare (code 2) returns reg_i unchanged as the result. C is set when reg_i >= opnd_i (unsigned) and Z when they are equal. N is bit 7 of (reg_i - opnd_i) mod 256. V is kept.
- R6: AND, OR and exclusive-OR (codes 3, 4, 5) combine reg_i with opnd_i. They set N from result bit 7 and Z from a zero result. C and V are kept.
- R7: Bit test (code 6) returns reg_i unchanged. Z is set when (reg_i & opnd_i) is zero, N takes opnd_i bit 7 and V takes opnd_i bit 6. C is kept.
- R8: Shift left (code 7) and rotate left (code 9) act on opnd_i. Bit 7 moves into C. Bit 0 of the result receives 0 for the shift and the old C for the rotate. N and Z follow the result and V is kept.
- R9: Logical shift right (code 8) and rotate right (code 10) act on opnd_i. Bit 0 moves into C. Bit 7 of the result receives 0 for the shift, so N is clear, and the old C for the rotate. Z follows the result and V is kept.
- R10: Load/transfer (code 11) returns opnd_i and updates only N and Z.
- R11: For every operation, status_o bits 3 and 2 equal status_i bits 3 and 2 as captured, and bits 5 and 4 are 1.
- R12: Unassigned codes 12–15 return reg_i and keep N, V, Z and C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Capture strobe for the output register |
| op_i | input | 4 | Operation code |
| reg_i | input | 8 | Accumulator or index register value |
| opnd_i | input | 8 | Memory operand |
| status_i | input | 8 | Current status byte |
| result_o | output | 8 | Registered result |
| status_o | output | 8 | Registered status byte |
| valid_o | output | 1 | Result captured on the previous edge |

## Verification
The bound checker holds several rules on every cycle:
- the fixed ones in status bits 5 and 4;
- pass-through of the D and I bits;
- holding the outputs when the strobe is low;
- compare carry as an unsigned ordering, and compare keeping the register;
- operand bits copied by bit test;
- the cleared N of logical shift right;
- preserved C and V under the logic operations.

Only the bench's scenarios show full arithmetic correctness against an independent signed-range model. That covers signed overflow on add and subtract, borrow-to-carry inversion, rotate carry paths, and the unassigned-code behaviour. Those scenarios combine random operands and random incoming status with directed sign-boundary cases.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int ST_N = 7;
  localparam int ST_V = 6;
  localparam int ST_D = 3;
  localparam int ST_I = 2;
  localparam int ST_Z = 1;
  localparam int ST_C = 0;
  localparam logic [7:0] ST_FIXED = 8'h30;

  typedef enum logic [3:0] {
    OP_ADC = 4'd0,
    OP_SBC = 4'd1,
    OP_CMP = 4'd2,
    OP_AND = 4'd3,
    OP_ORA = 4'd4,
    OP_EOR = 4'd5,
    OP_BIT = 4'd6,
    OP_ASL = 4'd7,
    OP_LSR = 4'd8,
    OP_ROL = 4'd9,
    OP_ROR = 4'd10,
    OP_LDV = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_sel_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         inv_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;

  assign b_eff  = inv_i ? ~b_i : b_i;
  assign full   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
  assign sum_o  = full[W-1:0];
  assign cout_o = full[W];
  // signed overflow: equal input signs, result sign differs
  assign ovf_o  = (a_i[W-1] == b_eff[W-1]) && (full[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_sel_e   sel_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = a_i & b_i;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] d_i,
  input  logic         cin_i,
  input  logic         left_i,
  input  logic         rot_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  logic fill;
  assign fill = rot_i & cin_i;

  always_comb begin
    if (left_i) begin
      res_o  = {d_i[W-2:0], fill};
      cout_o = d_i[W-1];
    end else begin
      res_o  = {fill, d_i[W-1:1]};
      cout_o = d_i[0];
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] reg_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [7:0]        status_i,
  output logic [DATA_W-1:0] result_o,
  output logic [7:0]        status_o,
  output logic              valid_o
);
  localparam int MSB = DATA_W - 1;

  alu_op_e      op;
  logic [MSB:0] as_sum, lg_res, sh_res, res_n;
  logic         as_cout, as_ovf, sh_cout;
  logic         as_inv, as_cin, sh_left, sh_rot;
  logic_sel_e   lg_sel;
  logic         n_n, v_n, z_n, c_n, upd_nz;
  logic [7:0]   st_n;

  assign op     = alu_op_e'(op_i);
  // subtract and compare add the inverted operand; compare ignores incoming carry
  assign as_inv = (op != OP_ADC);
  assign as_cin = (op == OP_CMP) ? 1'b1 : status_i[ST_C];

  alu8_addsub #(.W(DATA_W)) u_addsub (
    .a_i(reg_i), .b_i(opnd_i), .inv_i(as_inv), .cin_i(as_cin),
    .sum_o(as_sum), .cout_o(as_cout), .ovf_o(as_ovf)
  );

  always_comb begin
    unique case (op)
      OP_ORA:  lg_sel = LG_OR;
      OP_EOR:  lg_sel = LG_XOR;
      default: lg_sel = LG_AND;
    endcase
  end

  alu8_logic #(.W(DATA_W)) u_logic (
    .a_i(reg_i), .b_i(opnd_i), .sel_i(lg_sel), .res_o(lg_res)
  );

  assign sh_left = (op == OP_ASL) || (op == OP_ROL);
  assign sh_rot  = (op == OP_ROL) || (op == OP_ROR);

  alu8_shift #(.W(DATA_W)) u_shift (
    .d_i(opnd_i), .cin_i(status_i[ST_C]), .left_i(sh_left), .rot_i(sh_rot),
    .res_o(sh_res), .cout_o(sh_cout)
  );

  always_comb begin
    res_n  = reg_i;
    n_n    = status_i[ST_N];
    v_n    = status_i[ST_V];
    z_n    = status_i[ST_Z];
    c_n    = status_i[ST_C];
    upd_nz = 1'b0;
    case (op)
      OP_ADC, OP_SBC: begin
        res_n  = as_sum;
        c_n    = as_cout;
        v_n    = as_ovf;
        upd_nz = 1'b1;
      end
      OP_CMP: begin
        c_n = as_cout;
        z_n = (as_sum == '0);
        n_n = as_sum[MSB];
      end
      OP_AND, OP_ORA, OP_EOR: begin
        res_n  = lg_res;
        upd_nz = 1'b1;
      end
      OP_BIT: begin
        z_n = (lg_res == '0);
        n_n = opnd_i[MSB];
        v_n = opnd_i[MSB-1];
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        res_n  = sh_res;
        c_n    = sh_cout;
        upd_nz = 1'b1;
      end
      OP_LDV: begin
        res_n  = opnd_i;
        upd_nz = 1'b1;
      end
      default: ;
    endcase
    if (upd_nz) begin
      n_n = res_n[MSB];
      z_n = (res_n == '0);
    end
  end

  always_comb begin
    st_n       = status_i | ST_FIXED;
    st_n[ST_N] = n_n;
    st_n[ST_V] = v_n;
    st_n[ST_Z] = z_n;
    st_n[ST_C] = c_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      status_o <= ST_FIXED;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_n;
        status_o <= st_n;
      end
    end
  end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] reg_i,
  input logic [DATA_W-1:0] opnd_i,
  input logic [7:0]        status_i,
  input logic [DATA_W-1:0] result_o,
  input logic [7:0]        status_o,
  input logic              valid_o
);
  // R2
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o) && $stable(status_o)));

  // R11
  fixed_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[5:4] == 2'b11);

  // R11
  di_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> status_o[3:2] == $past(status_i[3:2]));

  // R5
  cmp_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd2) |=>
      (result_o == $past(reg_i)) && (status_o[0] == ($past(reg_i) >= $past(opnd_i))));

  // R7
  bit_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd6) |=>
      (status_o[7:6] == $past(opnd_i[DATA_W-1:DATA_W-2])) && (result_o == $past(reg_i)));

  // R9
  lsr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd8) |=> (!status_o[7] && status_o[0] == $past(opnd_i[0])));

  // R6
  logic_keep_cv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 4'd3 || op_i == 4'd4 || op_i == 4'd5)) |=>
      (status_o[6] == $past(status_i[6])) && (status_o[0] == $past(status_i[0])));
endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_alu8_core.sv
`timescale 1ns/1ps
module tb_alu8_core;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] reg_i = '0, opnd_i = '0, status_i = '0;
  logic [7:0] result_o, status_o;
  logic       valid_o;
  int checks = 0;
  int failures = 0;

  always #5 clk_i = ~clk_i;

  alu8_core dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .reg_i(reg_i), .opnd_i(opnd_i), .status_i(status_i),
    .result_o(result_o), .status_o(status_o), .valid_o(valid_o)
  );

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3, 4'd4, 4'd5: return "R6";
      4'd6: return "R7";
      4'd7, 4'd9: return "R8";
      4'd8, 4'd10: return "R9";
      4'd11: return "R10";
      default: return "R12";
    endcase
  endfunction

  // returns {result, status}
  function automatic logic [15:0] ref_model(input logic [3:0] op, input logic [7:0] a,
                                            input logic [7:0] m, input logic [7:0] st);
    int ai, mi, ci, sa, sm, t, sv;
    logic [7:0] r;
    logic n, v, z, c, nz;
    ai = a; mi = m; ci = st[0];
    sa = $signed(a); sm = $signed(m);
    r = a; n = st[7]; v = st[6]; z = st[1]; c = st[0]; nz = 1'b0;
    case (op)
      4'd0: begin
        t = ai + mi + ci; r = t[7:0]; c = (t > 255);
        sv = sa + sm + ci; v = (sv > 127) || (sv < -128); nz = 1'b1;
      end
      4'd1: begin
        t = ai - mi - (1 - ci); r = t[7:0]; c = (t >= 0);
        sv = sa - sm - (1 - ci); v = (sv > 127) || (sv < -128); nz = 1'b1;
      end
      4'd2: begin
        t = ai - mi; c = (ai >= mi); z = (ai == mi); n = t[7];
      end
      4'd3: begin r = a & m; nz = 1'b1; end
      4'd4: begin r = a | m; nz = 1'b1; end
      4'd5: begin r = a ^ m; nz = 1'b1; end
      4'd6: begin z = ((a & m) == 8'h00); n = m[7]; v = m[6]; end
      4'd7: begin r = {m[6:0], 1'b0}; c = m[7]; nz = 1'b1; end
      4'd8: begin r = {1'b0, m[7:1]}; c = m[0]; nz = 1'b1; end
      4'd9: begin r = {m[6:0], st[0]}; c = m[7]; nz = 1'b1; end
      4'd10: begin r = {st[0], m[7:1]}; c = m[0]; nz = 1'b1; end
      4'd11: begin r = m; nz = 1'b1; end
      default: ;
    endcase
    if (nz) begin n = r[7]; z = (r == 8'h00); end
    return {r, n, v, 2'b11, st[3], st[2], z, c};
  endfunction

  task automatic check8(input string req, input string what, input logic [7:0] act,
                        input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [7:0] a, input logic [7:0] m,
                        input logic [7:0] st);
    logic [15:0] e;
    e = ref_model(op, a, m, st);
    @(negedge clk_i);
    op_i = op; reg_i = a; opnd_i = m; status_i = st; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check8("R2", "valid_o", {7'd0, valid_o}, 8'h01);
    check8(req_of(op), "result", result_o, e[15:8]);
    check8(req_of(op), "status", status_o, e[7:0]);
    // R11 fixed bits and D/I pass-through
    check8("R11", "status[5:2]", {4'd0, status_o[5:2]}, {4'd0, 2'b11, st[3:2]});
    op_i = 4'($urandom); reg_i = 8'($urandom); opnd_i = 8'($urandom);
    status_i = 8'($urandom);
    @(negedge clk_i);
    // R2 hold while idle
    check8("R2", "idle valid_o", {7'd0, valid_o}, 8'h00);
    check8("R2", "idle result", result_o, e[15:8]);
    check8("R2", "idle status", status_o, e[7:0]);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_abcd));
    repeat (3) @(negedge clk_i);
    // R1 reset values
    check8("R1", "reset result", result_o, 8'h00);
    check8("R1", "reset status", status_o, 8'h30);
    check8("R1", "reset valid", {7'd0, valid_o}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check8("R1", "post-reset hold", status_o, 8'h30);

    // directed corners
    run_op(4'd0, 8'h50, 8'h50, 8'h30);   // R3 signed overflow -> A0, N V set
    run_op(4'd0, 8'hFF, 8'h00, 8'h31);   // R3 carry wrap to zero
    run_op(4'd1, 8'h00, 8'h01, 8'h31);   // R4 borrow -> FF, C clear
    run_op(4'd1, 8'h80, 8'h01, 8'h31);   // R4 overflow
    run_op(4'd2, 8'h42, 8'h42, 8'hF0);   // R5 equal
    run_op(4'd2, 8'h10, 8'h20, 8'h31);   // R5 less
    run_op(4'd6, 8'h0F, 8'hC0, 8'h31);   // R7 Z N V set
    run_op(4'd10, 8'h00, 8'h01, 8'h31);  // R9 rotate carry in/out
    run_op(4'd8, 8'h00, 8'hFF, 8'hFF);   // R9 N clear
    run_op(4'd9, 8'h00, 8'h80, 8'h30);   // R8 rotate to zero
    run_op(4'd11, 8'h55, 8'h00, 8'hCD);  // R10 zero load
    run_op(4'd13, 8'hA5, 8'h5A, 8'hC3);  // R12 unassigned

    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 40; k++) begin
        run_op(4'(op), 8'($urandom), 8'($urandom), {8'($urandom)} & 8'hFE | 8'(k & 1));
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule